// File: doc/BRIEF.md
# Maskable Fault Flag Reporter

This block gathers raw fault pulses from per-channel diagnostic circuits (open load, shorted string, single shorted LED) and from a global low-supply monitor, and turns them into sticky flag registers, a per-channel summary flag, a global error flag and an active-low open-drain error pin. Each channel has a diagnostic enable. When the enable is cleared, that channel's faults are ignored everywhere. Each fault type also has a mask bit. A masked type still records its own flag, but it never reaches the summary flags or the pin.

A small register port sets the masks and the enables, reads back every flag, and issues a self-clearing clear-fault command. There is no streaming data path, so the register port and all status pins are plain, single-cycle control signals with no valid/ready handshake and no back-pressure.

Each reportable fault event pulls the error pin low for a fixed number of clock cycles. A further event during that pulse neither restarts it nor extends it.

Top module: `fault_flag_reporter`

## Requirements
- R1: After reset, all flags are 0, `err_n` is 1, all diagnostic enables are 1 and all mask bits are 0.
- R2: A raw open, short or single-LED-short pulse on an enabled channel sets that channel's bit in `flag_open`, `flag_short` or `flag_sls` on the next cycle. The bit stays set until a clear-fault command.
- R3: While a channel's enable bit is 0, its raw faults set none of its type flags, its `flag_out` bit, `flag_err`, or the pin.
- R4: Mask bits live at register 1: bit 0 open, bit 1 short, bit 2 single-LED-short, bit 3 low-supply. A masked channel fault still sets its type flag, but it does not set `flag_out`, does not set `flag_err` and does not pulse `err_n`.
- R5: A low-supply pulse always sets `flag_lowsup`. It sets `flag_err`, and pulses the pin, only while mask bit 3 is 0.
- R6: A reportable event drives `err_n` low from the next cycle for exactly `PULSE_CYC` cycles.
- R7: A reportable event that occurs while `err_n` is low does not extend the pulse. An event after `err_n` has returned high starts a new pulse.
- R8: Writing 1 to bit 0 of register 0 clears every sticky flag on the next cycle. Register 0 always reads 0.
- R9: A fault arriving in the same cycle as a clear-fault write wins, and its flag remains set.
- R10: `cfg_rdata` combinationally returns the register selected by `cfg_addr`:
  - 0: control, reads 0
  - 1: masks
  - 2: enables
  - 3: open flags
  - 4: short flags
  - 5: single-LED-short flags
  - 6: global flags, with bit 0 `flag_lowsup` and bit 1 `flag_err`
  - any other address: 0
- R11: `flag_out[i]` is set by any enabled, unmasked fault of channel i, and is sticky until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data for `cfg_addr` |
| raw_open | input | NUM_CH | Raw open-load fault pulses |
| raw_short | input | NUM_CH | Raw short fault pulses |
| raw_sls | input | NUM_CH | Raw single-LED-short fault pulses |
| raw_lowsup | input | 1 | Raw low-supply fault pulse |
| flag_open | output | NUM_CH | Sticky open flags |
| flag_short | output | NUM_CH | Sticky short flags |
| flag_sls | output | NUM_CH | Sticky single-LED-short flags |
| flag_out | output | NUM_CH | Sticky per-channel summary flags |
| flag_lowsup | output | 1 | Sticky low-supply flag |
| flag_err | output | 1 | Sticky global error flag |
| err_n | output | 1 | Open-drain error pin, 0 = pulled low |

## Verification
The assertions assume that the raw fault inputs and the register port are synchronous to `clk` and settled at each rising edge. They also assume that no write lands on the mask or enable register in the same cycle as a fault whose masking the check relies on. The clear-fault properties additionally assume a cycle in which every raw input is idle.

The stimulus drives all inputs shortly after a rising edge and holds them for whole cycles. Mask and enable changes are separated from the fault pulses they govern by at least one cycle. The only overlap of clear-fault with a fault is the deliberate R9 case.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_MASK   = 3'd1,
    A_DIAGEN = 3'd2,
    A_FOPEN  = 3'd3,
    A_FSHORT = 3'd4,
    A_FSLS   = 3'd5,
    A_FGLOB  = 3'd6
  } ffr_addr_e;

  localparam int M_OPEN   = 0;
  localparam int M_SHORT  = 1;
  localparam int M_SLS    = 2;
  localparam int M_LOWSUP = 3;
  localparam int N_MASK   = 4;
endpackage

// File: rtl/ffr_sticky.sv
module ffr_sticky #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= set | (clr ? '0 : q);
  end
endmodule

// File: rtl/ffr_regs.sv
module ffr_regs
  import ffr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [NUM_CH-1:0] flag_open,
  input  logic [NUM_CH-1:0] flag_short,
  input  logic [NUM_CH-1:0] flag_sls,
  input  logic              flag_lowsup,
  input  logic              flag_err,
  output logic [N_MASK-1:0] mask_q,
  output logic [NUM_CH-1:0] diag_en,
  output logic              clr_req
);
  assign clr_req = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      diag_en <= '1;
    end else if (cfg_we) begin
      if (cfg_addr == A_MASK)   mask_q  <= cfg_wdata[N_MASK-1:0];
      if (cfg_addr == A_DIAGEN) diag_en <= cfg_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_MASK:   cfg_rdata[N_MASK-1:0] = mask_q;
      A_DIAGEN: cfg_rdata[NUM_CH-1:0] = diag_en;
      A_FOPEN:  cfg_rdata[NUM_CH-1:0] = flag_open;
      A_FSHORT: cfg_rdata[NUM_CH-1:0] = flag_short;
      A_FSLS:   cfg_rdata[NUM_CH-1:0] = flag_sls;
      A_FGLOB:  cfg_rdata[1:0]        = {flag_err, flag_lowsup};
      default:  cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ffr_err_pulse.sv
module ffr_err_pulse #(
  parameter int PULSE_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic err_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (cnt != '0)         cnt <= cnt - 1'b1;
    else if (evt)               cnt <= LOAD;
  end

  assign err_n = (cnt == '0);
endmodule

// File: rtl/fault_flag_reporter.sv
module fault_flag_reporter
  import ffr_pkg::*;
#(
  parameter int  NUM_CH    = 4,
  parameter int  PULSE_CYC = 2500,
  localparam int DW        = (NUM_CH > N_MASK) ? NUM_CH : N_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic [NUM_CH-1:0] raw_open,
  input  logic [NUM_CH-1:0] raw_short,
  input  logic [NUM_CH-1:0] raw_sls,
  input  logic              raw_lowsup,
  output logic [NUM_CH-1:0] flag_open,
  output logic [NUM_CH-1:0] flag_short,
  output logic [NUM_CH-1:0] flag_sls,
  output logic [NUM_CH-1:0] flag_out,
  output logic              flag_lowsup,
  output logic              flag_err,
  output logic              err_n
);
  logic [N_MASK-1:0] mask_q;
  logic [NUM_CH-1:0] diag_en;
  logic              clr_req;
  logic [NUM_CH-1:0] hit_open, hit_short, hit_sls, rep_ch;
  logic              lowsup_rep, evt;

  ffr_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .flag_open(flag_open), .flag_short(flag_short), .flag_sls(flag_sls),
    .flag_lowsup(flag_lowsup), .flag_err(flag_err),
    .mask_q(mask_q), .diag_en(diag_en), .clr_req(clr_req)
  );

  // Detection gated by the per-channel enable; reporting gated by type masks.
  assign hit_open  = raw_open  & diag_en;
  assign hit_short = raw_short & diag_en;
  assign hit_sls   = raw_sls   & diag_en;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_rep
    assign rep_ch[i] = (hit_open[i]  & ~mask_q[M_OPEN])
                     | (hit_short[i] & ~mask_q[M_SHORT])
                     | (hit_sls[i]   & ~mask_q[M_SLS]);
  end

  assign lowsup_rep = raw_lowsup & ~mask_q[M_LOWSUP];
  assign evt        = (|rep_ch) | lowsup_rep;

  ffr_sticky #(.W(NUM_CH)) u_f_open (
    .clk(clk), .rst_n(rst_n), .set(hit_open), .clr(clr_req), .q(flag_open));
  ffr_sticky #(.W(NUM_CH)) u_f_short (
    .clk(clk), .rst_n(rst_n), .set(hit_short), .clr(clr_req), .q(flag_short));
  ffr_sticky #(.W(NUM_CH)) u_f_sls (
    .clk(clk), .rst_n(rst_n), .set(hit_sls), .clr(clr_req), .q(flag_sls));
  ffr_sticky #(.W(NUM_CH)) u_f_out (
    .clk(clk), .rst_n(rst_n), .set(rep_ch), .clr(clr_req), .q(flag_out));
  ffr_sticky #(.W(1)) u_f_lowsup (
    .clk(clk), .rst_n(rst_n), .set(raw_lowsup), .clr(clr_req), .q(flag_lowsup));
  ffr_sticky #(.W(1)) u_f_err (
    .clk(clk), .rst_n(rst_n), .set(evt), .clr(clr_req), .q(flag_err));

  ffr_err_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .evt(evt), .err_n(err_n));
endmodule

// File: rtl/ffr_checker.sv
module ffr_checker
  import ffr_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int PULSE_CYC = 2500
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [AW-1:0]     cfg_addr,
  input logic              wbit0,
  input logic [NUM_CH-1:0] raw_open,
  input logic [NUM_CH-1:0] raw_short,
  input logic [NUM_CH-1:0] raw_sls,
  input logic              raw_lowsup,
  input logic [NUM_CH-1:0] flag_open,
  input logic [NUM_CH-1:0] flag_out,
  input logic              flag_lowsup,
  input logic              flag_err,
  input logic              err_n,
  input logic [NUM_CH-1:0] diag_en,
  input logic [N_MASK-1:0] mask_q
);
  localparam int RW = $clog2(PULSE_CYC + 2);

  logic          clr_wr, quiet;
  logic [RW-1:0] low_run;

  assign clr_wr = cfg_we && (cfg_addr == A_CTRL) && wbit0;
  assign quiet  = (raw_open == '0) && (raw_short == '0) && (raw_sls == '0) && !raw_lowsup;

  always_ff @(posedge clk) begin
    if (!rst_n)     low_run <= '0;
    else if (!err_n) low_run <= low_run + 1'b1;
    else            low_run <= '0;
  end

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((flag_open & $past(flag_open)) == $past(flag_open)));

  p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_open & ~$past(flag_open) & ~$past(diag_en)) == '0));

  p_pin_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> flag_err);

  p_lowsup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    raw_lowsup |=> flag_lowsup);

  p_lowsup_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_lowsup && !mask_q[M_LOWSUP]) |=> flag_err);

  p_pulse_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= RW'(PULSE_CYC));

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_n) |-> (low_run == RW'(PULSE_CYC)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && quiet) |=> (flag_open == '0 && flag_out == '0 && !flag_lowsup && !flag_err));

  p_fault_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && raw_lowsup) |=> flag_lowsup);
endmodule

bind fault_flag_reporter ffr_checker #(.NUM_CH(NUM_CH), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .wbit0(cfg_wdata[0]),
  .raw_open(raw_open), .raw_short(raw_short), .raw_sls(raw_sls), .raw_lowsup(raw_lowsup),
  .flag_open(flag_open), .flag_out(flag_out), .flag_lowsup(flag_lowsup),
  .flag_err(flag_err), .err_n(err_n), .diag_en(diag_en), .mask_q(mask_q)
);

// File: tb/sim_fault_flag_reporter.sv
module sim_fault_flag_reporter;
  localparam int NCH = 4;
  localparam int P   = 20;
  localparam int DW  = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_addr = '0;
  logic [DW-1:0]  cfg_wdata = '0;
  logic [DW-1:0]  cfg_rdata;
  logic [NCH-1:0] raw_open = '0, raw_short = '0, raw_sls = '0;
  logic           raw_lowsup = 1'b0;
  logic [NCH-1:0] flag_open, flag_short, flag_sls, flag_out;
  logic           flag_lowsup, flag_err, err_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  fault_flag_reporter #(.NUM_CH(NCH), .PULSE_CYC(P)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .raw_open(raw_open), .raw_short(raw_short), .raw_sls(raw_sls), .raw_lowsup(raw_lowsup),
    .flag_open(flag_open), .flag_short(flag_short), .flag_sls(flag_sls), .flag_out(flag_out),
    .flag_lowsup(flag_lowsup), .flag_err(flag_err), .err_n(err_n)
  );

  // Behavioural reference model
  logic [NCH-1:0] m_open, m_short, m_sls, m_out, m_en;
  logic [3:0]     m_mask;
  logic           m_low, m_err;
  int             m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open = '0; m_short = '0; m_sls = '0; m_out = '0;
      m_low = 0; m_err = 0; m_cnt = 0; m_en = '1; m_mask = '0;
    end else begin
      bit clr, ev;
      logic [NCH-1:0] rep;
      clr = cfg_we && cfg_addr == 3'd0 && cfg_wdata[0];
      for (int i = 0; i < NCH; i++) begin
        rep[i] = m_en[i] && ((raw_open[i] && !m_mask[0]) ||
                             (raw_short[i] && !m_mask[1]) ||
                             (raw_sls[i] && !m_mask[2]));
      end
      ev = (rep != 0) || (raw_lowsup && !m_mask[3]);
      if (clr) begin
        m_open = '0; m_short = '0; m_sls = '0; m_out = '0; m_low = 0; m_err = 0;
      end
      m_open  |= raw_open & m_en;
      m_short |= raw_short & m_en;
      m_sls   |= raw_sls & m_en;
      m_out   |= rep;
      if (raw_lowsup) m_low = 1;
      if (ev) m_err = 1;
      if (m_cnt > 0) m_cnt--;
      else if (ev) m_cnt = P;
      if (cfg_we && cfg_addr == 3'd1) m_mask = cfg_wdata;
      if (cfg_we && cfg_addr == 3'd2) m_en = cfg_wdata;
    end
  end

  function automatic logic [DW-1:0] m_rd(logic [2:0] a);
    case (a)
      3'd1: return m_mask;
      3'd2: return m_en;
      3'd3: return m_open;
      3'd4: return m_short;
      3'd5: return m_sls;
      3'd6: return {2'b00, m_err, m_low};
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 flag_open",   32'(flag_open),   32'(m_open));
      chk("R2 flag_short",  32'(flag_short),  32'(m_short));
      chk("R2 flag_sls",    32'(flag_sls),    32'(m_sls));
      chk("R11 flag_out",   32'(flag_out),    32'(m_out));
      chk("R5 flag_lowsup", 32'(flag_lowsup), 32'(m_low));
      chk("R4 flag_err",    32'(flag_err),    32'(m_err));
      chk("R6 err_n",       32'(err_n),       32'(m_cnt == 0));
      chk("R10 cfg_rdata",  32'(cfg_rdata),   32'(m_rd(cfg_addr)));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    step(); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(); cfg_we = 0;
  endtask

  task automatic fpulse(logic [NCH-1:0] o, logic [NCH-1:0] s, logic [NCH-1:0] l, logic ls);
    step(); raw_open = o; raw_short = s; raw_sls = l; raw_lowsup = ls;
    step(); raw_open = '0; raw_short = '0; raw_sls = '0; raw_lowsup = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    cfg_addr = 3'd2; #1;
    chk("R1 enables", 32'(cfg_rdata), 32'hF);
    chk("R1 flags",   32'({flag_open, flag_short, flag_sls, flag_out, flag_lowsup, flag_err}), 0);
    chk("R1 err_n",   32'(err_n), 1);
    cfg_addr = 3'd1; #1;
    chk("R1 masks",   32'(cfg_rdata), 0);

    // R2/R6: open fault on ch0, measure pulse length
    fpulse(4'b0001, 0, 0, 0);
    chk("R2 open set", 32'(flag_open), 32'h1);
    n = 0;
    while (!err_n) begin n++; step(); end
    chk("R6 pulse length", n, P);
    idle(3);
    chk("R2 sticky", 32'(flag_open), 32'h1);

    // R7: second event during pulse does not extend
    fpulse(0, 4'b0010, 0, 0);
    n = 0;
    while (!err_n) begin
      n++;
      raw_sls = (n == 5) ? 4'b0100 : '0;
      step();
    end
    raw_sls = '0;
    chk("R7 no extension", n, P);
    fpulse(0, 0, 4'b1000, 0);
    chk("R7 new pulse", 32'(err_n), 0);
    idle(P + 2);

    // R8: clear-fault
    wr(3'd0, 4'b0001);
    chk("R8 cleared", 32'({flag_open, flag_short, flag_sls, flag_out, flag_lowsup, flag_err}), 0);
    cfg_addr = 3'd0; #1;
    chk("R8 ctrl reads 0", 32'(cfg_rdata), 0);

    // R3: disable channel 0
    wr(3'd2, 4'b1110);
    fpulse(4'b0001, 4'b0001, 4'b0001, 0);
    chk("R3 no type flags", 32'({flag_open, flag_short, flag_sls}), 0);
    chk("R3 no summary", 32'({flag_out, flag_err, err_n}), 32'h1);
    wr(3'd2, 4'b1111);

    // R4: mask open type
    wr(3'd1, 4'b0001);
    fpulse(4'b1000, 0, 0, 0);
    chk("R4 type flag kept", 32'(flag_open), 32'h8);
    chk("R4 not reported", 32'({flag_out, flag_err, err_n}), 32'h1);

    // R5: masked and unmasked low supply
    wr(3'd1, 4'b1000);
    fpulse(0, 0, 0, 1);
    chk("R5 lowsup set", 32'(flag_lowsup), 1);
    chk("R5 masked no err", 32'({flag_err, err_n}), 32'h1);
    wr(3'd0, 4'b0001);
    wr(3'd1, 4'b0000);
    fpulse(0, 0, 0, 1);
    chk("R5 unmasked err", 32'({flag_lowsup, flag_err, err_n}), 32'h6);
    idle(P + 2);

    // R9: fault together with clear
    step(); cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 4'b0001; raw_short = 4'b0100;
    step(); cfg_we = 0; raw_short = '0;
    chk("R9 fault wins", 32'(flag_short), 32'h4);
    chk("R9 others cleared", 32'(flag_lowsup), 0);

    // R11 / R10: flag_out per channel, readback
    fpulse(0, 0, 4'b0010, 0);
    chk("R11 flag_out", 32'(flag_out), 32'h6);
    cfg_addr = 3'd5; #1;
    chk("R10 read sls", 32'(cfg_rdata), 32'h2);
    cfg_addr = 3'd7; #1;
    chk("R10 unused addr", 32'(cfg_rdata), 0);
    idle(P + 4);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule